// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes an accepted receive frame as a byte stream and places it in memory through a ring of two-word receive descriptors. Each descriptor names a word-aligned buffer. The block fills that buffer with up to `buf_units × 64` bytes, then writes the descriptor back. The write-back hands the descriptor to software and records start-of-frame, end-of-frame, the reported length and the address-filter result. The block then moves to the next descriptor in the ring.

All memory traffic goes through one request/response port, one 32-bit access at a time. Frame bytes are packed little-endian into words and written with byte enables. After each write-back the block fetches the next descriptor at once. If software still owns that descriptor, the block raises a no-buffer status and an event. It then holds `s_ready` low until receive is re-enabled and a fresh fetch finds a usable descriptor. Because refusal is only ever a low `s_ready`, no byte of the stream is dropped. CRC generation belongs to the frame source: when the FCS is kept, the source supplies the four extra bytes.

Top module: `rx_ring_writer`

## Requirements
- R1: Once `mem_req` is raised it stays high, with `mem_addr` and `mem_wdata` unchanged, until the cycle `mem_ack` is seen; each request is one 32-bit access.
- R2: Descriptor word 0 (at the descriptor address) has bit 0 = ownership (1 = owned by software), bit 1 = wrap, and bits 31:2 = the word-aligned buffer address. After a descriptor is filled, word 0 is written back equal to the fetched value with bit 0 set.
- R3: Descriptor word 1 (at the descriptor address + 4) is written whole. Bit 14 is set only on the first descriptor of a frame. Bit 15 is set only on the last. Bits 12:0 hold the reported length on the last descriptor and zero on the others.
- R4: Filter input `s_kind` selects the upper bits of word 1 on every descriptor of the frame. The encoding is 0 promiscuous (no bit), 1 broadcast (bit 31), 2 multicast hash (bit 30), 3 unicast hash (bit 29), and 4 specific-address match (bit 27, with `s_slot` in bits 26:25). All other upper bits are zero.
- R5: With L = `s_len` and F = 4 when `keep_fcs` is 1, else 0, the block takes exactly L+F bytes from the stream. It reports max(L,60)+F as the length. Bytes go little-endian into consecutive buffer bytes. A descriptor is closed once it holds `buf_units`×64 bytes, and bytes past the copied count in the last word are left untouched.
- R6: After a write-back the pointer goes to `q_base` if the wrap bit was set, else it advances by 8. The first enable after reset starts the ring at `q_base`, and later enables resume at the current pointer.
- R7: The next descriptor is read right after each write-back. If its ownership bit is 1, `sts_no_buf` is set and `evt_buf_used` pulses for one cycle.
- R8: `s_ready` is low while `rx_en` is low or while the current descriptor is owned by software. A rising `rx_en` fetches the current descriptor again.
- R9: When the last descriptor of a frame has been written back, `sts_frame_rcvd` is set and `evt_rx_done` pulses for one cycle.
- R10: After reset, `s_ready`, `mem_req`, both status bits and both events are 0, and no memory access starts before `rx_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| q_base | input | AW | Byte address of the first descriptor of the ring |
| buf_units | input | BSZ_W | Buffer size in units of 64 bytes (at least 1) |
| keep_fcs | input | 1 | 1: the stream carries 4 FCS bytes that are stored and counted |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_len | input | LEN_W | Frame length without FCS, sampled with the first byte |
| s_kind | input | 3 | Filter result kind, sampled with the first byte |
| s_slot | input | 2 | Matching address slot for kind 4 |
| s_ready | output | 1 | Byte accepted on this cycle when high with `s_valid` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| sts_frame_rcvd | output | 1 | Sticky: a frame has completed |
| sts_no_buf | output | 1 | Sticky: a fetched descriptor was owned by software |
| evt_rx_done | output | 1 | One-cycle frame-complete event |
| evt_buf_used | output | 1 | One-cycle used-buffer event |

## Verification
Frames are driven with lengths below, at and above the 60-byte floor, with the FCS both kept and stripped. The copied count lands exactly on, just past and well past one 64-byte buffer, which separates the copied count from the reported one and checks where descriptors are split. Each filter kind is used at least once and the ring wraps several times, so a flag written on the wrong descriptor or a pointer that skips the wrap stands out. A frame with a 128-byte buffer confirms the capacity follows `buf_units`. A ring with a software-owned descriptor checks the no-buffer report, the refusal on `s_ready`, and the resume at the same descriptor after re-enabling.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    FLT_PROMISC = 3'd0,
    FLT_BCAST   = 3'd1,
    FLT_MHASH   = 3'd2,
    FLT_UHASH   = 3'd3,
    FLT_SPEC    = 3'd4
  } flt_kind_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_RECV  = 3'd2,
    S_WDATA = 3'd3,
    S_WB1   = 3'd4,
    S_WB0   = 3'd5
  } wr_state_e;

  // word 0 field positions
  localparam int W0_OWN  = 0;
  localparam int W0_WRAP = 1;
  // word 1 field positions
  localparam int W1_SOF     = 14;
  localparam int W1_EOF     = 15;
  localparam int W1_SLOT_LO = 25;
  localparam int W1_SPEC    = 27;
  localparam int W1_UHASH   = 29;
  localparam int W1_MHASH   = 30;
  localparam int W1_BCAST   = 31;

  localparam int MIN_REPORT = 60;
  localparam int FCS_BYTES  = 4;

endpackage

// File: rtl/rxr_len_calc.sv
module rxr_len_calc
  import rxr_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic [LEN_W-1:0] len,
  input  logic             keep,
  output logic [LEN_W-1:0] copy_n,
  output logic [LEN_W-1:0] report_n
);

  localparam logic [LEN_W-1:0] FLOOR = LEN_W'(MIN_REPORT);
  localparam logic [LEN_W-1:0] EXTRA = LEN_W'(FCS_BYTES);

  logic [LEN_W-1:0] fcs_add;
  logic [LEN_W-1:0] padded;

  always_comb begin
    fcs_add  = keep ? EXTRA : '0;
    padded   = (len < FLOOR) ? FLOOR : len;
    copy_n   = len + fcs_add;
    report_n = padded + fcs_add;
  end

endmodule

// File: rtl/rxr_status_enc.sv
module rxr_status_enc
  import rxr_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic             first,
  input  logic             last,
  input  logic [LEN_W-1:0] report_n,
  input  logic [2:0]       kind,
  input  logic [1:0]       slot,
  output logic [31:0]      word1
);

  always_comb begin
    word1 = '0;
    if (last) begin
      word1[LEN_W-1:0] = report_n;
      word1[W1_EOF]    = 1'b1;
    end
    if (first) word1[W1_SOF] = 1'b1;
    case (kind)
      FLT_BCAST: word1[W1_BCAST] = 1'b1;
      FLT_MHASH: word1[W1_MHASH] = 1'b1;
      FLT_UHASH: word1[W1_UHASH] = 1'b1;
      FLT_SPEC: begin
        word1[W1_SPEC]               = 1'b1;
        word1[W1_SLOT_LO+1:W1_SLOT_LO] = slot;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rxr_mem_port.sv
module rxr_mem_port #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [3:0]    be,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else if (mem_req) begin
      if (mem_ack) mem_req <= 1'b0;
    end else if (go) begin
      mem_req   <= 1'b1;
      mem_we    <= we;
      mem_addr  <= addr;
      mem_wdata <= wdata;
      mem_be    <= be;
    end
  end

  assign done = mem_req & mem_ack;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R1

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LEN_W    = 13,
  parameter int BSZ_W    = 8,
  parameter int BUF_UNIT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic [AW-1:0]    q_base,
  input  logic [BSZ_W-1:0] buf_units,
  input  logic             keep_fcs,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic [LEN_W-1:0] s_len,
  input  logic [2:0]       s_kind,
  input  logic [1:0]       s_slot,
  output logic             s_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             sts_frame_rcvd,
  output logic             sts_no_buf,
  output logic             evt_rx_done,
  output logic             evt_buf_used
);

  localparam int UNIT_SH = $clog2(BUF_UNIT);
  localparam int CAP_W   = BSZ_W + UNIT_SH;
  localparam logic [AW-1:0] DESC_STEP = AW'(8);
  localparam logic [AW-1:0] W1_OFS    = AW'(4);

  wr_state_e        state;
  logic             en_q, fetch_pend, have_desc, frame_act, first_d, dfull;
  logic [AW-1:0]    ptr;
  logic [31:0]      w0;
  logic [LEN_W-1:0] frm_left, rep_len;
  logic [2:0]       kind_q;
  logic [1:0]       slot_q;
  logic [CAP_W-1:0] buf_off;
  logic [31:0]      pack;
  logic [3:0]       pack_be;
  logic [1:0]       pack_n;

  // length arithmetic for the frame about to start
  logic [LEN_W-1:0] copy_c, report_c;
  rxr_len_calc #(.LEN_W(LEN_W)) u_len (
    .len(s_len), .keep(keep_fcs), .copy_n(copy_c), .report_n(report_c)
  );

  // status word for the descriptor being closed
  logic [31:0] w1_c;
  rxr_status_enc #(.LEN_W(LEN_W)) u_enc (
    .first(first_d), .last(frm_left == '0), .report_n(rep_len),
    .kind(kind_q), .slot(slot_q), .word1(w1_c)
  );

  // memory command
  logic          go_c, we_c, done;
  logic [AW-1:0] addr_c;
  logic [31:0]   wdata_c;
  logic [3:0]    be_c;
  logic [AW-1:0] buf_base;

  assign buf_base = {w0[AW-1:2], 2'b00};

  always_comb begin
    go_c    = 1'b0;
    we_c    = 1'b0;
    addr_c  = ptr;
    wdata_c = '0;
    be_c    = 4'hF;
    case (state)
      S_FETCH: go_c = 1'b1;
      S_WDATA: begin
        go_c    = 1'b1;
        we_c    = 1'b1;
        addr_c  = buf_base + AW'(buf_off);
        wdata_c = pack;
        be_c    = pack_be;
      end
      S_WB1: begin
        go_c    = 1'b1;
        we_c    = 1'b1;
        addr_c  = ptr + W1_OFS;
        wdata_c = w1_c;
      end
      S_WB0: begin
        go_c    = 1'b1;
        we_c    = 1'b1;
        wdata_c = w0 | (32'd1 << W0_OWN);
      end
      default: ;
    endcase
  end

  rxr_mem_port #(.AW(AW)) u_port (
    .clk(clk), .rst(rst), .go(go_c), .we(we_c), .addr(addr_c),
    .wdata(wdata_c), .be(be_c), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack)
  );

  // byte acceptance
  logic             fire;
  logic [LEN_W-1:0] rem_c;
  logic [CAP_W-1:0] cap_c;
  logic             full_c;

  assign s_ready = (state == S_RECV) && rx_en && have_desc;
  assign fire    = s_valid && s_ready;

  always_comb begin
    rem_c  = (frame_act ? frm_left : copy_c) - LEN_W'(1);
    cap_c  = CAP_W'(buf_units) << UNIT_SH;
    full_c = (buf_off + CAP_W'(pack_n) + CAP_W'(1)) >= cap_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= S_IDLE;
      en_q           <= 1'b0;
      fetch_pend     <= 1'b0;
      have_desc      <= 1'b0;
      frame_act      <= 1'b0;
      first_d        <= 1'b0;
      dfull          <= 1'b0;
      ptr            <= '0;
      w0             <= '0;
      frm_left       <= '0;
      rep_len        <= '0;
      kind_q         <= '0;
      slot_q         <= '0;
      buf_off        <= '0;
      pack           <= '0;
      pack_be        <= '0;
      pack_n         <= '0;
      sts_frame_rcvd <= 1'b0;
      sts_no_buf     <= 1'b0;
      evt_rx_done    <= 1'b0;
      evt_buf_used   <= 1'b0;
    end else begin
      en_q         <= rx_en;
      evt_rx_done  <= 1'b0;
      evt_buf_used <= 1'b0;
      if (rx_en && !en_q) fetch_pend <= 1'b1;

      case (state)
        S_IDLE: begin
          if (fetch_pend) begin
            fetch_pend <= 1'b0;
            ptr        <= q_base;
            state      <= S_FETCH;
          end
        end

        S_FETCH: begin
          if (done) begin
            w0      <= mem_rdata;
            buf_off <= '0;
            if (mem_rdata[W0_OWN]) begin
              have_desc    <= 1'b0;
              sts_no_buf   <= 1'b1;
              evt_buf_used <= 1'b1;
            end else begin
              have_desc <= 1'b1;
            end
            state <= S_RECV;
          end
        end

        S_RECV: begin
          if (fire) begin
            if (!frame_act) begin
              frame_act <= 1'b1;
              first_d   <= 1'b1;
              rep_len   <= report_c;
              kind_q    <= s_kind;
              slot_q    <= s_slot;
            end
            frm_left                <= rem_c;
            pack[{pack_n, 3'b000} +: 8] <= s_data;
            pack_be[pack_n]         <= 1'b1;
            pack_n                  <= pack_n + 2'd1;
            dfull                   <= full_c;
            if (pack_n == 2'd3 || rem_c == '0 || full_c) state <= S_WDATA;
          end else if (fetch_pend) begin
            fetch_pend <= 1'b0;
            if (!have_desc) state <= S_FETCH;
          end
        end

        S_WDATA: begin
          if (done) begin
            buf_off <= buf_off + CAP_W'(4);
            pack    <= '0;
            pack_be <= '0;
            pack_n  <= '0;
            state   <= (dfull || frm_left == '0) ? S_WB1 : S_RECV;
          end
        end

        S_WB1: begin
          if (done) state <= S_WB0;
        end

        S_WB0: begin
          if (done) begin
            ptr       <= w0[W0_WRAP] ? q_base : ptr + DESC_STEP;
            first_d   <= 1'b0;
            dfull     <= 1'b0;
            have_desc <= 1'b0;
            if (frm_left == '0) begin
              frame_act      <= 1'b0;
              sts_frame_rcvd <= 1'b1;
              evt_rx_done    <= 1'b1;
            end
            state <= S_FETCH;
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  AST_NOBUF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_no_buf) |-> !s_ready); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    evt_rx_done |=> !evt_rx_done); // R9

  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB1) && mem_req && mem_wdata[W1_EOF] |-> mem_wdata[LEN_W-1:0] >= LEN_W'(MIN_REPORT)); // R5

  AST_OWN_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB0) && mem_req |-> mem_we && mem_wdata[W0_OWN]); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) && ($past(state) != S_IDLE) && (ptr != $past(ptr))
      |-> (ptr == q_base) || (ptr == $past(ptr) + DESC_STEP)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !mem_req && !s_ready); // R10

endmodule

// File: tb/rx_ring_writer_bench.sv
`timescale 1ns/1ps
module rx_ring_writer_bench;

  localparam int QB    = 32'h40;
  localparam int BUF0  = 32'h100;
  localparam int BSTEP = 32'h80;
  localparam int NSLOT = 4;
  localparam int NVEC  = 8;

  // [31:16] length, [12] keep FCS, [10:8] filter kind, [1:0] slot
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0014_0000, 32'h0064_0100, 32'h003C_1200, 32'h003D_1300,
    32'h000A_1402, 32'h0082_0403, 32'h003B_0100, 32'h0040_0300
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0;
  logic [31:0] q_base = QB;
  logic [7:0]  buf_units = 8'd1;
  logic        keep_fcs = 1'b0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic [12:0] s_len = '0;
  logic [2:0]  s_kind = '0;
  logic [1:0]  s_slot = '0;
  logic        s_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        sts_frame_rcvd, sts_no_buf, evt_rx_done, evt_buf_used;

  always #2.5 clk = ~clk;

  rx_ring_writer u_rx_ring_writer (
    .clk(clk), .rst(rst), .rx_en(rx_en), .q_base(q_base),
    .buf_units(buf_units), .keep_fcs(keep_fcs),
    .s_valid(s_valid), .s_data(s_data), .s_len(s_len), .s_kind(s_kind),
    .s_slot(s_slot), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .sts_frame_rcvd(sts_frame_rcvd),
    .sts_no_buf(sts_no_buf), .evt_rx_done(evt_rx_done),
    .evt_buf_used(evt_buf_used)
  );

  int checks = 0;
  int fails  = 0;

  // memory model with one-cycle acknowledge and a bench write port
  logic [31:0] mem [256];
  logic        tb_wr = 1'b0;
  logic [7:0]  tb_idx = '0;
  logic [31:0] tb_dat = '0;
  int          n_reads = 0;
  logic [31:0] last_rd = '0;
  int          n_done = 0, n_used = 0, r1_bad = 0;
  logic        pend_q = 1'b0;
  logic [31:0] pend_addr = '0;

  always @(posedge clk) begin
    if (tb_wr) mem[tb_idx] <= tb_dat;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
        n_reads   <= n_reads + 1;
        last_rd   <= mem_addr;
      end
    end else begin
      mem_ack <= 1'b0;
    end
    if (!rst) begin
      if (evt_rx_done) n_done <= n_done + 1;
      if (evt_buf_used) n_used <= n_used + 1;
      if (pend_q && (!mem_req || mem_addr != pend_addr)) r1_bad <= r1_bad + 1;
      pend_q    <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (got %0d cycles, expected < 150000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk);
    tb_wr = 1'b1; tb_idx = 8'(idx); tb_dat = d;
    @(negedge clk);
    tb_wr = 1'b0;
  endtask

  function automatic logic [31:0] armed_w0(input int s);
    return 32'(BUF0 + BSTEP * s) | ((s == NSLOT - 1) ? 32'h2 : 32'h0);
  endfunction

  task automatic arm_ring();
    for (int s = 0; s < NSLOT; s++) begin
      poke((QB >> 2) + 2 * s, armed_w0(s));
      poke((QB >> 2) + 2 * s + 1, 32'h0);
    end
    for (int w = BUF0 >> 2; w < (BUF0 + BSTEP * NSLOT) >> 2; w++) poke(w, 32'h0);
  endtask

  function automatic logic [7:0] rd_byte(input int a);
    return mem[a >> 2][8 * (a % 4) +: 8];
  endfunction

  task automatic send_frame(input int len, input bit keep, input int kind,
                            input int slot, input int seed);
    int copy;
    copy = len + (keep ? 4 : 0);
    keep_fcs = keep;
    for (int i = 0; i < copy; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = 8'(seed + i); s_len = 13'(len);
      s_kind = 3'(kind); s_slot = 2'(slot);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (n_done < target) @(posedge clk);
    repeat (12) @(posedge clk);
  endtask

  // compare every descriptor and buffer of one frame against the requirements
  task automatic check_frame(input int len, input bit keep, input int kind,
                             input int slot, input int seed, input int units,
                             inout int cur);
    int copy, rep, cap, nd, nb, bad, s, da;
    logic [31:0] e1;
    copy = len + (keep ? 4 : 0);
    rep  = ((len < 60) ? 60 : len) + (keep ? 4 : 0);
    cap  = units * 64;
    nd   = (copy + cap - 1) / cap;
    for (int d = 0; d < nd; d++) begin
      s  = (cur + d) % NSLOT;
      da = QB + 8 * s;
      check(mem[da >> 2] == (armed_w0(s) | 32'h1), "R2", "word0 ownership",
            mem[da >> 2], armed_w0(s) | 32'h1);
      e1 = '0;
      if (d == 0) e1[14] = 1'b1;
      if (d == nd - 1) begin e1[15] = 1'b1; e1[12:0] = 13'(rep); end
      case (kind)
        1: e1[31] = 1'b1;
        2: e1[30] = 1'b1;
        3: e1[29] = 1'b1;
        4: begin e1[27] = 1'b1; e1[26:25] = 2'(slot); end
        default: ;
      endcase
      check(mem[(da >> 2) + 1] == e1, "R3/R4", "word1 status",
            mem[(da >> 2) + 1], e1);
      nb  = (copy - d * cap < cap) ? copy - d * cap : cap;
      bad = 0;
      for (int j = 0; j < nb; j++)
        if (rd_byte(BUF0 + BSTEP * s + j) != 8'(seed + d * cap + j)) bad++;
      check(bad == 0, "R5", "buffer bytes wrong", 32'(bad), 32'h0);
      if (d == nd - 1 && nb < BSTEP)
        check(rd_byte(BUF0 + BSTEP * s + nb) == 8'h00, "R5", "byte past copy touched",
              32'(rd_byte(BUF0 + BSTEP * s + nb)), 32'h0);
    end
    cur = (cur + nd) % NSLOT;
  endtask

  int cur_slot = 0;
  int frames   = 0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!s_ready && !mem_req, "R10", "ready/req after reset",
          {30'h0, s_ready, mem_req}, 32'h0);
    check(!sts_frame_rcvd && !sts_no_buf && !evt_rx_done && !evt_buf_used, "R10",
          "status after reset",
          {28'h0, sts_frame_rcvd, sts_no_buf, evt_rx_done, evt_buf_used}, 32'h0);
    arm_ring();
    // R8 refused while disabled, R10 no access before enable
    @(negedge clk);
    s_valid = 1'b1;
    repeat (5) @(negedge clk);
    check(!s_ready, "R8", "ready while disabled", 32'(s_ready), 32'h0);
    check(n_reads == 0, "R10", "memory reads before enable", 32'(n_reads), 32'h0);
    s_valid = 1'b0;
    rx_en = 1'b1;
    repeat (10) @(negedge clk);
    check(n_reads == 1 && last_rd == QB, "R6", "first fetch address", last_rd, QB);

    // table of frames, one buffer unit
    for (int v = 0; v < NVEC; v++) begin
      int len, kind, slot, seed;
      bit keep;
      len  = int'(VEC[v][31:16]);
      keep = VEC[v][12];
      kind = int'(VEC[v][10:8]);
      slot = int'(VEC[v][1:0]);
      seed = v * 29 + 3;
      arm_ring();
      send_frame(len, keep, kind, slot, seed);
      frames++;
      wait_done(frames);
      check(n_done == frames, "R9", "frame-complete events", 32'(n_done), 32'(frames));
      check(sts_frame_rcvd, "R9", "frame-received status", 32'(sts_frame_rcvd), 32'h1);
      check_frame(len, keep, kind, slot, seed, 1, cur_slot);
    end
    check(n_used == 0 && !sts_no_buf, "R7", "no-buffer raised with free ring",
          32'(n_used), 32'h0);

    // capacity follows the buffer-size field: 130 bytes in 128-byte buffers
    buf_units = 8'd2;
    arm_ring();
    send_frame(130, 1'b0, 3, 0, 77);
    frames++;
    wait_done(frames);
    check_frame(130, 1'b0, 3, 0, 77, 2, cur_slot);
    buf_units = 8'd1;

    // next descriptor owned by software
    arm_ring();
    poke((QB >> 2) + 2 * ((cur_slot + 1) % NSLOT), armed_w0((cur_slot + 1) % NSLOT) | 32'h1);
    send_frame(20, 1'b0, 1, 0, 5);
    frames++;
    wait_done(frames);
    check_frame(20, 1'b0, 1, 0, 5, 1, cur_slot);
    check(n_used == 1, "R7", "used-buffer events", 32'(n_used), 32'h1);
    check(sts_no_buf, "R7", "no-buffer status", 32'(sts_no_buf), 32'h1);
    @(negedge clk);
    s_valid = 1'b1;
    repeat (4) @(negedge clk);
    check(!s_ready, "R8", "ready with software-owned descriptor", 32'(s_ready), 32'h0);
    s_valid = 1'b0;
    // hand the descriptor back and re-enable
    poke((QB >> 2) + 2 * cur_slot, armed_w0(cur_slot));
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    repeat (10) @(negedge clk);
    check(last_rd == 32'(QB + 8 * cur_slot), "R8", "refetch address",
          last_rd, 32'(QB + 8 * cur_slot));
    check(s_ready, "R8", "ready after re-enable", 32'(s_ready), 32'h1);
    send_frame(30, 1'b1, 4, 1, 90);
    frames++;
    wait_done(frames);
    check_frame(30, 1'b1, 4, 1, 90, 1, cur_slot);   // R6 resumes at same descriptor
    check(r1_bad == 0, "R1", "request dropped or changed before ack", 32'(r1_bad), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule